// File: doc/BRIEF.md
# Timer Input Capture Unit

This unit records the value of a free-running 16-bit timer at the moment a chosen event is seen on an external capture input. The input is synchronised into the clock domain. An edge detector and an optional event divider then decide which transitions count as capture events. On each such event the unit copies one of two timer sources into a holding register and raises a request flag, which stays high until software clears it.

A 4-bit mode field selects the event. It can be any rising edge, any falling edge, every 4th rising edge or every 16th rising edge; every other code switches capture off. The event divider is cleared only when the unit leaves capture mode. A direct change from one divide ratio to another therefore keeps the partial count, and the first capture after such a change can arrive early. Software that wants a clean start passes through the off code first. The holding register has no overrun protection: a later capture simply replaces an earlier one.

Top module: `tmr_capture_unit`

## Requirements
- R1: On a capture event the holding register `cap_value` takes the full 16-bit value of `timer_a` when `tsel` is 0, or of `timer_b` when `tsel` is 1, as presented at the clock edge on which the event is taken.
- R2: Mode code 4'b0101 captures on every rising edge of `cap_pin`. Mode code 4'b0100 captures on every falling edge only; rising edges do not capture in that mode.
- R3: Mode code 4'b0110 captures on every 4th rising edge and mode code 4'b0111 on every 16th rising edge, counted from a cleared divider. The rising edges in between leave `cap_value` and `cap_flag` unchanged.
- R4: Each capture sets `cap_flag`. The flag stays set until a cycle in which `flag_clr` is high and no capture happens, and it is low on the following cycle.
- R5: A capture that arrives while `cap_flag` is still set overwrites `cap_value` with the new timer value.
- R6: Mode code 4'b0000 and every code outside 4'b0100 to 4'b0111 mean capture is off: edges on `cap_pin` change neither `cap_value` nor `cap_flag`.
- R7: The event divider is cleared on every cycle in which the mode is not a capture code. After a pass through an off code, a divided mode again needs the full 4 or 16 rising edges.
- R8: Switching directly between 4'b0110 and 4'b0111 keeps the divider count. For example, after 2 rising edges in 4'b0110, switching to 4'b0111 makes the 14th following rising edge capture.
- R9: When `flag_clr` is high in the same cycle as a capture, the capture wins and `cap_flag` stays set.
- R10: After reset `cap_value` is 0, `cap_flag` is 0 and the divider count is 0.
- R11: `cap_pin` passes through a two-flop synchroniser. A level change that is set up before clock edge k is reflected in `cap_value` after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input |
| timer_a | input | 16 | First timer source |
| timer_b | input | 16 | Second timer source |
| mode | input | 4 | Event mode code |
| tsel | input | 1 | Timer source select (0: timer_a, 1: timer_b) |
| flag_clr | input | 1 | Software strobe that clears the request flag |
| cap_value | output | 16 | Captured timer value |
| cap_flag | output | 1 | Capture request flag |

## Verification
Two functions can fall in the same cycle: a software clear of the flag and the setting of the flag by a new capture. The bench provokes this by raising `cap_pin`, then holding `flag_clr` high for exactly the cycle whose edge performs the capture. That cycle is the third edge after the pin change. The bench expects the flag to stay set and the new timer value to be held, and a later clear on its own must then drop the flag. The divider-carry case is the other point of interest: a direct switch of divide ratio must fire on the 14th rising edge, where a fresh count would need the 16th.

// File: rtl/cap_pkg.sv
// Package: shared mode codes and helpers for the timer input capture unit.
// Assumes mode codes are 4 bits wide; every code outside 0100..0111 means off.
package cap_pkg;

    typedef enum logic [3:0] {
        CM_OFF    = 4'b0000,
        CM_FALL   = 4'b0100,
        CM_RISE   = 4'b0101,
        CM_DIV4   = 4'b0110,
        CM_DIV16  = 4'b0111
    } cap_mode_e;

    // True when the code selects one of the four capture modes.
    function automatic logic is_capture(input logic [3:0] m);
        return (m == CM_FALL) || (m == CM_RISE) || (m == CM_DIV4) || (m == CM_DIV16);
    endfunction

    // True when the code selects a divided rising-edge mode.
    function automatic logic is_divided(input logic [3:0] m);
        return (m == CM_DIV4) || (m == CM_DIV16);
    endfunction

endpackage

// File: rtl/cap_edge_sync.sv
// Module: synchronises an asynchronous input through STAGES flops and flags
// rising and falling transitions of the synchronised level.
// Assumes STAGES >= 2; the edge outputs are single-cycle combinational pulses.
module cap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
    end

    // Keep the previous synchronised sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Compare current and previous synchronised samples.
    always_comb begin
        rise = sync_q[STAGES-1] & ~prev_q;
        fall = ~sync_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/cap_prescale.sv
// Module: turns synchronised edges into capture events according to the mode.
// The divider count only advances in divided modes, is kept across a direct
// ratio change, and is cleared whenever the mode is not a capture code.
// Assumes CW >= 2 so that the fast terminal count of 3 fits.
module cap_prescale
    import cap_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    mode,
    input  logic          rise,
    input  logic          fall,
    output logic          evt,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] TERM_FAST = CW'(3);
    localparam logic [CW-1:0] TERM_SLOW = {CW{1'b1}};

    logic [CW-1:0] term;
    logic          at_term;

    // Pick the terminal count for the selected divide ratio.
    always_comb begin
        term    = (mode == CM_DIV16) ? TERM_SLOW : TERM_FAST;
        at_term = (cnt == term);
    end

    // Decide whether this cycle's edge is a qualified capture event.
    always_comb begin
        unique case (mode)
            CM_FALL:  evt = fall;
            CM_RISE:  evt = rise;
            CM_DIV4,
            CM_DIV16: evt = rise & at_term;
            default:  evt = 1'b0;
        endcase
    end

    // Advance, wrap or clear the divider count.
    always_ff @(posedge clk) begin
        if (!rst_n || !is_capture(mode)) cnt <= '0;
        else if (is_divided(mode) && rise) cnt <= at_term ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/cap_store.sv
// Module: holding register and request flag. On load it copies the selected
// timer and sets the flag; a clear strobe drops the flag unless a load coincides.
// Assumes both timer sources are synchronous to clk.
module cap_store #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          tsel,
    input  logic [TW-1:0] ta,
    input  logic [TW-1:0] tb,
    input  logic          clr,
    output logic [TW-1:0] value,
    output logic          flag
);

    // Copy the selected timer on each capture event.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= tsel ? tb : ta;
    end

    // Set on capture, clear on strobe, capture takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (load) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

endmodule

// File: rtl/tmr_capture_unit.sv
// Module: top of the timer input capture unit. Chains the synchroniser/edge
// detector, the event divider and the holding register.
// Assumes the capture pin is asynchronous and the timers are clk-synchronous.
module tmr_capture_unit #(
    parameter int TW     = 16,
    parameter int STAGES = 2,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_pin,
    input  logic [TW-1:0] timer_a,
    input  logic [TW-1:0] timer_b,
    input  logic [3:0]    mode,
    input  logic          tsel,
    input  logic          flag_clr,
    output logic [TW-1:0] cap_value,
    output logic          cap_flag
);

    logic          pin_rise;
    logic          pin_fall;
    logic          cap_evt;
    logic [CW-1:0] ps_cnt;

    cap_edge_sync #(.STAGES(STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (cap_pin),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    cap_prescale #(.CW(CW)) i_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .rise  (pin_rise),
        .fall  (pin_fall),
        .evt   (cap_evt),
        .cnt   (ps_cnt)
    );

    cap_store #(.TW(TW)) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_evt),
        .tsel  (tsel),
        .ta    (timer_a),
        .tb    (timer_b),
        .clr   (flag_clr),
        .value (cap_value),
        .flag  (cap_flag)
    );

endmodule

// File: rtl/tmr_capture_unit_chk.sv
// Module: assertion checker bound to the capture unit top.
// Assumes it is attached by the bind statement at the end of this file.
module tmr_capture_unit_chk
    import cap_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [TW-1:0] timer_a,
    input logic [TW-1:0] timer_b,
    input logic [3:0]    mode,
    input logic          tsel,
    input logic          flag_clr,
    input logic [TW-1:0] cap_value,
    input logic          cap_flag,
    input logic          cap_evt,
    input logic [CW-1:0] ps_cnt
);

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_value == ($past(tsel) ? $past(timer_b) : $past(timer_a))); // R1

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag); // R9

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag); // R4

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cap_evt) |=> !cap_flag); // R4

    AST_VALUE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_value)); // R5

    AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode) |=> $stable(cap_value)); // R6

    AST_DIVIDER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !is_capture(mode) |=> ps_cnt == '0); // R7

endmodule

bind tmr_capture_unit tmr_capture_unit_chk #(.TW(TW), .CW(CW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_a   (timer_a),
    .timer_b   (timer_b),
    .mode      (mode),
    .tsel      (tsel),
    .flag_clr  (flag_clr),
    .cap_value (cap_value),
    .cap_flag  (cap_flag),
    .cap_evt   (cap_evt),
    .ps_cnt    (ps_cnt)
);

// File: tb/test_tmr_capture_unit.sv
module test_tmr_capture_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic [15:0] timer_a = '0;
    logic [15:0] timer_b = '0;
    logic [3:0]  mode = 4'b0000;
    logic        tsel = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_value;
    logic        cap_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tmr_capture_unit i_tmr_capture_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pin   (cap_pin),
        .timer_a   (timer_a),
        .timer_b   (timer_b),
        .mode      (mode),
        .tsel      (tsel),
        .flag_clr  (flag_clr),
        .cap_value (cap_value),
        .cap_flag  (cap_flag)
    );

    typedef struct packed {
        logic [3:0]  md;
        logic        ts;
        logic [15:0] ta;
        logic [15:0] tb;
        logic [4:0]  np;
        logic        ef;
        logic [15:0] ev;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{4'b0101, 1'b0, 16'h1111, 16'h2222, 5'd1,  1'b1, 16'h1111}, // R1 R2 rise, timer_a
        '{4'b0101, 1'b1, 16'h3333, 16'h4444, 5'd1,  1'b1, 16'h4444}, // R1 timer_b
        '{4'b0100, 1'b0, 16'h5555, 16'h0001, 5'd1,  1'b1, 16'h5555}, // R2 fall
        '{4'b0110, 1'b0, 16'h6666, 16'h0002, 5'd3,  1'b0, 16'h5555}, // R3 3 of 4
        '{4'b0110, 1'b0, 16'h7777, 16'h0003, 5'd4,  1'b1, 16'h7777}, // R3 4th
        '{4'b0111, 1'b0, 16'h8888, 16'h0004, 5'd15, 1'b0, 16'h7777}, // R3 15 of 16
        '{4'b0111, 1'b1, 16'h0005, 16'h9999, 5'd16, 1'b1, 16'h9999}, // R3 16th
        '{4'b0000, 1'b0, 16'hAAAA, 16'h0006, 5'd2,  1'b0, 16'h9999}, // R6 off
        '{4'b0011, 1'b0, 16'hBBBB, 16'h0007, 5'd2,  1'b0, 16'h9999}, // R6 other code
        '{4'b1101, 1'b0, 16'hCCCC, 16'h0008, 5'd2,  1'b0, 16'h9999}  // R6 other code
    };

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cap_pin = 1'b1; tick(3);
            cap_pin = 1'b0; tick(3);
        end
        tick(2);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; tick(1);
        flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        tick(20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        tick(3);
        chk("R10 value after reset", cap_value, 16'h0000);
        chk("R10 flag after reset", {15'd0, cap_flag}, 16'h0001 & 16'h0000);
        rst_n = 1'b1;
        tick(2);

        // Vector table.
        for (int v = 0; v < NV; v++) begin
            mode = 4'b0000; tick(2);
            clear_flag();
            tsel = VEC[v].ts; timer_a = VEC[v].ta; timer_b = VEC[v].tb;
            mode = VEC[v].md; tick(1);
            pulses(int'(VEC[v].np));
            chk($sformatf("R1-table vector %0d value", v), cap_value, VEC[v].ev);
            chk($sformatf("R4-table vector %0d flag", v), {15'd0, cap_flag}, {15'd0, VEC[v].ef});
        end

        // R11: latency through synchroniser.
        mode = 4'b0000; tick(2); clear_flag();
        tsel = 1'b0; timer_a = 16'h1234; mode = 4'b0101; tick(1);
        cap_pin = 1'b1; tick(2);
        chk("R11 not yet after two edges", cap_value, 16'h9999);
        tick(1);
        chk("R11 captured after third edge", cap_value, 16'h1234);
        cap_pin = 1'b0; tick(4);

        // R4: flag held without clear.
        tick(20);
        chk("R4 flag held", {15'd0, cap_flag}, 16'h0001);

        // R5: overwrite while flag set.
        timer_a = 16'h2468; pulses(1);
        chk("R5 overwrite value", cap_value, 16'h2468);

        // R9: clear and capture in the same cycle.
        timer_a = 16'hABCD;
        cap_pin = 1'b1; tick(2);
        flag_clr = 1'b1; tick(1);
        flag_clr = 1'b0;
        chk("R9 flag kept", {15'd0, cap_flag}, 16'h0001);
        chk("R9 value", cap_value, 16'hABCD);
        clear_flag();
        chk("R4 clear alone", {15'd0, cap_flag}, 16'h0000);
        cap_pin = 1'b0; tick(4);

        // R2: rising edge ignored in falling mode.
        mode = 4'b0100; timer_a = 16'h0F0F; tick(1);
        cap_pin = 1'b1; tick(5);
        chk("R2 rise ignored flag", {15'd0, cap_flag}, 16'h0000);
        chk("R2 rise ignored value", cap_value, 16'hABCD);
        cap_pin = 1'b0; tick(4);
        chk("R2 fall captured", cap_value, 16'h0F0F);

        // R7: off clears the divider.
        mode = 4'b0000; tick(2); clear_flag();
        mode = 4'b0110; timer_a = 16'h1357; tick(1);
        pulses(2);
        mode = 4'b0000; tick(2);
        mode = 4'b0110; tick(1);
        pulses(3);
        chk("R7 no early capture", {15'd0, cap_flag}, 16'h0000);
        pulses(1);
        chk("R7 full count capture", {15'd0, cap_flag}, 16'h0001);
        chk("R7 value", cap_value, 16'h1357);

        // R8: direct ratio switch keeps the count.
        mode = 4'b0000; tick(2); clear_flag();
        mode = 4'b0110; timer_a = 16'h8642; tick(1);
        pulses(2);
        mode = 4'b0111; tick(1);
        pulses(13);
        chk("R8 no capture after 13", {15'd0, cap_flag}, 16'h0000);
        pulses(1);
        chk("R8 capture on 14th", {15'd0, cap_flag}, 16'h0001);
        chk("R8 value", cap_value, 16'h8642);

        done = 1'b1;
        finish_run();
    end

endmodule